// File: doc/BRIEF.md
# Load/Store Address Checker and Aligner

This block sits between the load/store stage of a 32-bit processor and a word-wide data memory. Each cycle it may receive one access request: a byte address, an access size, a read/write flag, store data, the current privilege mode and a flag that selects unsigned loads. In the same cycle it decides whether the access is legal. An access is legal when the address is naturally aligned for its size and the privilege mode allows that region. A legal access reaches the memory as an enable, a write enable, per-byte lane enables, a word address and lane-steered store data.

An illegal access never reaches the memory. On the following cycle the block raises a one-cycle exception with a reason code, and it keeps the faulting address in a bad-address register until the next fault. For loads, the memory is taken to return its word one cycle after the request. The block remembers the size, offset and signedness of the access. It then moves the addressed byte or half-word down to bit 0 and extends it to 32 bits, little-endian. The lowest address maps to the least significant byte.

Top module: `mem_access_guard`

## Requirements
- R1: While reset is high and in the first cycle after it, exc_valid is 0, exc_cause is 00, bad_addr is 0 and load_valid is 0.
- R2: For a legal access, mem_be is 0001 shifted left by addr[1:0] for size code 00 (byte), 0011 shifted left by addr[1:0] for size code 01 (half-word), and 1111 for size codes 10 and 11 (word). When mem_en is low, mem_be is 0000.
- R3: In the cycle of a legal request, mem_en is 1, mem_we equals the write flag, and mem_addr is the request address with bits 1:0 cleared. mem_wdata carries the low store byte in all four lanes for a byte, the low half-word in both halves for a half-word, and the whole word for a word.
- R4: A half-word at an odd address, or a word whose address bits 1:0 are not 00, is misaligned and illegal. Byte accesses are never misaligned.
- R5: In user mode (user_mode = 1), an address with bit 31 set (0x80000000 and above) is a privilege violation and is illegal.
- R6: In the cycle of an illegal request, mem_en and mem_we are 0. In the next cycle exc_valid is 1, and exc_cause is 01 for misaligned or 10 for a privilege violation, with 01 winning when both apply. After a cycle with no illegal request, exc_valid is 0 and exc_cause is 00.
- R7: bad_addr takes the full address of an illegal request and shows it from the next cycle on. It holds that value until the next illegal request.
- R8: One cycle after a legal load, load_valid is 1. load_data is then the addressed byte or half-word of that cycle's mem_rdata moved down to bit 0, or the whole word for a word load. load_valid is 0 after any other cycle.
- R9: For byte and half-word loads, the bits above the loaded field copy its top bit when load_unsigned was 0 at the request, and are zero when it was 1.
- R10: In kernel mode (user_mode = 0), any aligned address is legal, including those with bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data, right-aligned |
| user_mode | input | 1 | 1 = user mode, 0 = kernel mode |
| load_unsigned | input | 1 | 1 = zero-extend loads, 0 = sign-extend |
| mem_rdata | input | 32 | Memory read word, one cycle after the request |
| mem_en | output | 1 | Legal access issued to memory |
| mem_we | output | 1 | Legal store issued to memory |
| mem_be | output | 4 | Byte-lane enables |
| mem_addr | output | 32 | Word address to memory |
| mem_wdata | output | 32 | Lane-steered store data |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_cause | output | 2 | 01 misaligned, 10 privilege, 00 none |
| bad_addr | output | 32 | Address of the latest illegal access |
| load_valid | output | 1 | load_data is valid this cycle |
| load_data | output | 32 | Aligned and extended load result |

## Verification
The memory-side outputs (mem_en, mem_we, mem_be, mem_addr, mem_wdata) depend only on the current request. The bench checks them a short delay after it drives the inputs, within the same cycle. exc_valid, exc_cause, bad_addr and load_valid appear one edge later. load_data combines the lane choice kept from the previous request with the mem_rdata driven in the current cycle. The bench model therefore holds the previous request's expectations for one step and compares them after the next input drive, before the following edge. All sampling happens in the low phase of the clock, away from the rising edge.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int OFS_W    = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_ALIGN = 2'b01,
        FLT_PRIV  = 2'b10
    } fault_e;

    typedef struct packed {
        logic             word;
        logic             half;
        logic [OFS_W-1:0] ofs;
        logic             uns;
    } lane_sel_t;

    function automatic lane_sel_t decode_lanes(input logic [1:0] size,
                                               input logic [OFS_W-1:0] ofs,
                                               input logic uns);
        lane_sel_t s;
        s.word = size[1];
        s.half = (size == SZ_HALF);
        s.ofs  = ofs;
        s.uns  = uns;
        return s;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input lane_sel_t s);
        logic [LANES-1:0] m;
        if (s.word)
            m = '1;
        else if (s.half)
            m = LANES'(2'b11) << s.ofs;
        else
            m = LANES'(1'b1) << s.ofs;
        return m;
    endfunction

endpackage

// File: rtl/lsu_legality.sv
module lsu_legality
    import lsu_pkg::*;
(
    input  logic             top_bit,
    input  logic [OFS_W-1:0] low_bits,
    input  lane_sel_t        sel,
    input  logic             user_mode,
    output fault_e           why
);
    logic misaligned;
    logic forbidden;

    always_comb begin
        if (sel.word)
            misaligned = |low_bits;
        else if (sel.half)
            misaligned = low_bits[0];
        else
            misaligned = 1'b0;
        forbidden = user_mode & top_bit;
        if (misaligned)
            why = FLT_ALIGN;
        else if (forbidden)
            why = FLT_PRIV;
        else
            why = FLT_NONE;
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_pkg::*;
(
    input  lane_sel_t          sel,
    input  logic               enable,
    input  logic [DATA_W-1:0]  wdata_in,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata_out
);
    assign be = enable ? lane_mask(sel) : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (sel.word)
                wdata_out[8*i +: 8] = wdata_in[8*i +: 8];
            else if (sel.half)
                wdata_out[8*i +: 8] = wdata_in[8*(i % 2) +: 8];
            else
                wdata_out[8*i +: 8] = wdata_in[7:0];
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  lane_sel_t         sel,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] shifted;
    logic              fill;

    always_comb begin
        shifted = rdata >> {sel.ofs, 3'b000};
        if (sel.word) begin
            fill  = 1'b0;
            value = rdata;
        end else if (sel.half) begin
            fill  = ~sel.uns & shifted[15];
            value = {{(DATA_W-16){fill}}, shifted[15:0]};
        end else begin
            fill  = ~sel.uns & shifted[7];
            value = {{(DATA_W-8){fill}}, shifted[7:0]};
        end
    end
endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              user_mode,
    input  logic              load_unsigned,
    input  logic [31:0]       mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              exc_valid,
    output logic [1:0]        exc_cause,
    output logic [ADDR_W-1:0] bad_addr,
    output logic              load_valid,
    output logic [31:0]       load_data
);
    lane_sel_t  sel_now;
    lane_sel_t  sel_q;
    fault_e     why;
    fault_e     cause_q;
    logic       legal;
    logic       exc_q;
    logic       ld_q;
    logic [ADDR_W-1:0] bad_q;

    assign sel_now = decode_lanes(req_size, req_addr[OFS_W-1:0], load_unsigned);

    lsu_legality u_legal (
        .top_bit   (req_addr[ADDR_W-1]),
        .low_bits  (req_addr[OFS_W-1:0]),
        .sel       (sel_now),
        .user_mode (user_mode),
        .why       (why)
    );

    assign legal    = req_valid && (why == FLT_NONE);
    assign mem_en   = legal;
    assign mem_we   = legal && req_write;
    assign mem_addr = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

    lsu_store_steer u_store (
        .sel       (sel_now),
        .enable    (legal),
        .wdata_in  (req_wdata),
        .be        (mem_be),
        .wdata_out (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_q   <= 1'b0;
            cause_q <= FLT_NONE;
            bad_q   <= '0;
            ld_q    <= 1'b0;
            sel_q   <= '0;
        end else begin
            exc_q   <= req_valid && (why != FLT_NONE);
            cause_q <= req_valid ? why : FLT_NONE;
            if (req_valid && (why != FLT_NONE))
                bad_q <= req_addr;
            ld_q    <= legal && !req_write;
            if (legal && !req_write)
                sel_q <= sel_now;
        end
    end

    lsu_load_extract u_load (
        .sel   (sel_q),
        .rdata (mem_rdata),
        .value (load_data)
    );

    assign exc_valid  = exc_q;
    assign exc_cause  = cause_q;
    assign bad_addr   = bad_q;
    assign load_valid = ld_q;
endmodule

// File: rtl/mem_access_guard_sva.sv
module mem_access_guard_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              user_mode,
    input logic              mem_en,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic              exc_valid,
    input logic [1:0]        exc_cause,
    input logic [ADDR_W-1:0] bad_addr,
    input logic              load_valid
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!exc_valid && !load_valid && bad_addr == '0));

    a_r2_byte_single_lane: assert property (@(posedge clk) disable iff (rst)
        (mem_en && req_size == 2'b00) |-> ($countones(mem_be) == 1));

    a_r2_idle_no_lanes: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (mem_be == 4'b0000));

    a_r3_we_needs_en: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_en && req_write));

    a_r4_word_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_en && req_size[1]) |-> (req_addr[1:0] == 2'b00));

    a_r5_user_low_half: assert property (@(posedge clk) disable iff (rst)
        (mem_en && user_mode) |-> !req_addr[ADDR_W-1]);

    a_r6_reject_raises: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mem_en) |=> (exc_valid && exc_cause != 2'b00));

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || mem_en) |=> !exc_valid);

    a_r6_cause_code: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_cause == 2'b01 || exc_cause == 2'b10));

    a_r7_bad_addr_holds: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> $stable(bad_addr));

    a_r8_load_follows: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> load_valid);
endmodule

bind mem_access_guard mem_access_guard_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .user_mode  (user_mode),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .exc_valid  (exc_valid),
    .exc_cause  (exc_cause),
    .bad_addr   (bad_addr),
    .load_valid (load_valid)
);

// File: tb/mem_access_guard_test.sv
module mem_access_guard_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        user_mode = 1'b0;
    logic        load_unsigned = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_en, mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr, mem_wdata;
    logic        exc_valid;
    logic [1:0]  exc_cause;
    logic [31:0] bad_addr;
    logic        load_valid;
    logic [31:0] load_data;

    always #5 clk = ~clk;

    mem_access_guard uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .user_mode(user_mode), .load_unsigned(load_unsigned), .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .bad_addr(bad_addr), .load_valid(load_valid), .load_data(load_data)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // expectations carried from one step to the next
    logic [31:0] exp_bad = '0;
    logic        exp_exc = 1'b0;
    logic [1:0]  exp_cause = 2'b00;
    string       exc_tag = "R6";
    logic        exp_lv = 1'b0;
    int          ld_bytes = 0;
    int          ld_ofs = 0;
    logic        ld_uns = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int size_bytes(input logic [1:0] sz);
        if (sz == 2'b00) return 1;
        if (sz == 2'b01) return 2;
        return 4;
    endfunction

    task automatic step(input logic v, input logic w, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic um, input logic uns, input logic [31:0] rd);
        int n;
        int ofs;
        int fault;
        logic [31:0] ebe;
        logic [31:0] ewd;
        logic [31:0] eld;
        req_valid = v; req_write = w; req_size = sz; req_addr = a;
        req_wdata = wd; user_mode = um; load_unsigned = uns; mem_rdata = rd;
        #1;
        // results of the previous request
        check(exc_tag, "exc_valid", {31'b0, exc_valid}, {31'b0, exp_exc});
        check(exc_tag, "exc_cause", {30'b0, exc_cause}, {30'b0, exp_cause});
        check("R7", "bad_addr", bad_addr, exp_bad);
        check("R8", "load_valid", {31'b0, load_valid}, {31'b0, exp_lv});
        if (exp_lv) begin
            eld = 0;
            for (int k = 0; k < ld_bytes; k++)
                eld = eld | (((rd >> (8 * (ld_ofs + k))) & 32'hFF) << (8 * k));
            if (ld_bytes < 4 && !ld_uns && eld[8 * ld_bytes - 1])
                eld = eld | (32'hFFFF_FFFF << (8 * ld_bytes));
            check(ld_bytes < 4 ? "R9" : "R8", "load_data", load_data, eld);
        end
        // this request
        n = size_bytes(sz);
        ofs = int'(a[1:0]);
        fault = 0;
        if (ofs % n != 0) fault = 1;
        else if (um && a[31]) fault = 2;
        if (v && fault == 0) begin
            ebe = 0;
            for (int k = 0; k < n; k++) ebe = ebe | (32'd1 << (ofs + k));
            ewd = 0;
            for (int k = 0; k < 4; k++) ewd = ewd | (((wd >> (8 * (k % n))) & 32'hFF) << (8 * k));
            check(a[31] ? "R10" : "R3", "mem_en", {31'b0, mem_en}, 32'd1);
            check("R3", "mem_we", {31'b0, mem_we}, {31'b0, w});
            check("R3", "mem_addr", mem_addr, {a[31:2], 2'b00});
            check("R2", "mem_be", {28'b0, mem_be}, ebe);
            if (w) check("R3", "mem_wdata", mem_wdata, ewd);
        end else begin
            check(fault == 1 ? "R4" : (fault == 2 ? "R5" : "R6"), "mem_en",
                  {31'b0, mem_en}, 32'd0);
            check("R6", "mem_we", {31'b0, mem_we}, 32'd0);
            check("R2", "mem_be", {28'b0, mem_be}, 32'd0);
        end
        exp_exc = v && fault != 0;
        exp_cause = v ? 2'(fault) : 2'b00;
        exc_tag = (fault == 1) ? "R4" : (fault == 2) ? "R5" : "R6";
        if (v && fault != 0) exp_bad = a;
        exp_lv = v && !w && fault == 0;
        ld_bytes = n; ld_ofs = ofs; ld_uns = uns;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'b00, 32'h0, 32'h0, 1'b0, 1'b0, $urandom);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "exc_valid", {31'b0, exc_valid}, 32'd0);
        check("R1", "exc_cause", {30'b0, exc_cause}, 32'd0);
        check("R1", "bad_addr", bad_addr, 32'd0);
        check("R1", "load_valid", {31'b0, load_valid}, 32'd0);
        @(negedge clk);
        // byte stores on every lane (R2, R3)
        for (int o = 0; o < 4; o++)
            step(1, 1, 2'b00, 32'h0000_1000 + o, 32'hAABB_CC5A, 1, 0, 0);
        // half and word stores
        step(1, 1, 2'b01, 32'h0000_2000, 32'h1234_BEEF, 1, 0, 0);
        step(1, 1, 2'b01, 32'h0000_2002, 32'h1234_BEEF, 1, 0, 0);
        step(1, 1, 2'b10, 32'h0000_2004, 32'hCAFE_F00D, 1, 0, 0);
        // misaligned (R4) and privilege (R5), with priority (R6)
        step(1, 1, 2'b01, 32'h0000_3001, 32'h1, 0, 0, 0);
        step(1, 0, 2'b10, 32'h0000_3002, 32'h1, 0, 0, 0);
        step(1, 1, 2'b00, 32'h8000_0000, 32'h1, 1, 0, 0);
        step(1, 0, 2'b10, 32'hFFFF_FFFE, 32'h1, 1, 0, 0);
        idle();
        // kernel reaches upper half (R10)
        step(1, 1, 2'b10, 32'h8000_0010, 32'h5555_AAAA, 0, 0, 0);
        // loads with both extensions (R8, R9)
        step(1, 0, 2'b00, 32'h0000_0103, 0, 1, 0, 0);
        step(1, 0, 2'b00, 32'h0000_0103, 0, 1, 1, 32'h80FF_7F01);
        step(1, 0, 2'b01, 32'h0000_0102, 0, 1, 0, 32'h80FF_7F01);
        step(1, 0, 2'b01, 32'h0000_0100, 0, 1, 0, 32'h80FF_7F01);
        step(1, 0, 2'b11, 32'h0000_0104, 0, 1, 1, 32'h8001_8001);
        idle();
        // randomized traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(0, 1) == 0) a[31] = 1'b0;
            if ($urandom_range(0, 2) != 0) a[1:0] = 2'b00;
            step($urandom_range(0, 5) != 0, 1'($urandom), 2'($urandom), a,
                 $urandom, 1'($urandom), 1'($urandom), $urandom);
        end
        idle();
        idle();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule